// File: doc/BRIEF.md
# Shared-stage FP issue scheduler

This block decides, cycle by cycle, whether a floating-point operation may start. The arithmetic unit behind it owns exactly one copy of each of eight stage resources: unpack (U), shift (S), add (A), round (R), exception test (E), multiply first half (M), multiply second half (N) and divide (D). Every operation class walks these stages in a fixed pattern, and some stages are used several times or together with others. A stage can serve only one operation per cycle.

The scheduler holds a table of which stages are already promised to earlier operations for each upcoming cycle. When a request arrives, the pattern of the requested class is laid over the table. If no stage is double-booked, the request is granted and its pattern is merged into the table in the same cycle. Otherwise the request is refused for that cycle and must be presented again. A per-class completion bit pulses once the granted operation has run its full length. Operand dependencies and the arithmetic itself are handled elsewhere.

Top module: `fp_stage_issue`

## Requirements
- R1: While `rst` is high at a rising edge, `grant_o`, `stall_o` and `done_o` are all zero in the following cycle. Reset also forgets every reservation and every pending completion, so the first request after reset is granted at once.
- R2: Each cycle in which `req_valid_i` is high at the rising edge is a request cycle. It produces exactly one of `grant_o` or `stall_o` high during the next cycle. A cycle with no request leaves both low.
- R3: Op codes and stage use, where step 0 is the request cycle: 0 add/subtract is U, S+A, A+R, R+S. 1 multiply is U, E+M, M, M, M, N, N+A, R. 2 divide is U, A, R, then D for `DIV_D_CYCLES` steps (27 by default), then D+A, D+R, D+A, D+R, A, R. 3 negate/absolute is U, S. 4 compare is U, A, R.
- R4: A request is granted only when none of its stages at step j is already held for that cycle by an operation granted earlier. A grant reserves all of its stages.
- R5: An add requested 1 to 7 cycles after a multiply stalls only at offsets 4 and 5. At offset 4 it waits two cycles; at offset 5 it waits one.
- R6: A multiply requested 1 or 2 cycles after an add never stalls. A divide requested 1 cycle after an add stalls once. A divide requested 2 cycles after an add goes at once.
- R7: With the default divide length, an add requested 28 to 33 cycles after a divide stalls until offset 34. Offsets 27 and 34 issue at once.
- R8: Same-class repeats: an add needs 3 cycles of spacing, a multiply 4, and negate and compare 1 each. Two divides 31 cycles apart cost one stall.
- R9: A stalled request that is held high is retried every cycle. It is granted in the first cycle in which it fits.
- R10: `done_o` has one bit per class: 0 add, 1 multiply, 2 divide, 3 negate, 4 compare. The bit is high for exactly one cycle, L cycles after the request cycle in which the operation was granted. L is 4 for add, 8 for multiply, 9 + `DIV_D_CYCLES` (36 by default) for divide, 2 for negate and 3 for compare. Different classes can finish in the same cycle.
- R11: Op codes 5, 6 and 7 behave exactly as negate (code 3), including completing on `done_o[3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Operation request present this cycle |
| req_op_i | input | 3 | Operation class code of the request |
| grant_o | output | 1 | Registered: previous cycle's request was issued |
| stall_o | output | 1 | Registered: previous cycle's request was refused |
| done_o | output | 5 | Registered one-cycle completion pulse per class |

## Verification
The issue verdict for a request cycle is due one cycle later, so the bench drives on falling edges and reads `grant_o` or `stall_o` at the next falling edge. Each stalled cycle adds one more falling edge before the grant, and the bench counts these against the expected number of stalls for that offset. A class's completion bit is due L cycles after its granted request cycle, which is L-1 falling edges after the grant was seen. The bench checks that the bit is high there and low one edge later. Every vector starts from an idle stretch longer than the longest pattern, so the offsets are measured against an empty table.

// File: rtl/fpsi_pkg.sv
package fpsi_pkg;

  localparam int unsigned NUM_STAGES = 8;
  localparam int unsigned NUM_CLS    = 5;
  localparam int unsigned OP_W       = 3;

  // stage bit positions in a reservation mask
  localparam int unsigned ST_U = 0;
  localparam int unsigned ST_S = 1;
  localparam int unsigned ST_A = 2;
  localparam int unsigned ST_R = 3;
  localparam int unsigned ST_E = 4;
  localparam int unsigned ST_M = 5;
  localparam int unsigned ST_N = 6;
  localparam int unsigned ST_D = 7;

  typedef logic [NUM_STAGES-1:0] stage_mask_t;

  typedef enum logic [2:0] {
    CLS_ADD = 3'd0,
    CLS_MUL = 3'd1,
    CLS_DIV = 3'd2,
    CLS_NEG = 3'd3,
    CLS_CMP = 3'd4
  } op_cls_e;

  function automatic stage_mask_t bit_of(input int unsigned s);
    stage_mask_t m;
    m = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  // codes above the last class fold onto negate
  function automatic op_cls_e decode_op(input logic [OP_W-1:0] code);
    case (code)
      3'd0:    return CLS_ADD;
      3'd1:    return CLS_MUL;
      3'd2:    return CLS_DIV;
      3'd4:    return CLS_CMP;
      default: return CLS_NEG;
    endcase
  endfunction

  function automatic int unsigned cls_latency(input op_cls_e c, input int unsigned div_d);
    case (c)
      CLS_ADD: return 4;
      CLS_MUL: return 8;
      CLS_DIV: return 9 + div_d;
      CLS_CMP: return 3;
      default: return 2;
    endcase
  endfunction

  // stages a class occupies 'step' cycles after its request cycle
  function automatic stage_mask_t stage_use(input op_cls_e c, input int unsigned step,
                                            input int unsigned div_d);
    stage_mask_t m;
    int unsigned k;
    m = '0;
    case (c)
      CLS_ADD: begin
        case (step)
          0: m = bit_of(ST_U);
          1: m = bit_of(ST_S) | bit_of(ST_A);
          2: m = bit_of(ST_A) | bit_of(ST_R);
          3: m = bit_of(ST_R) | bit_of(ST_S);
          default: m = '0;
        endcase
      end
      CLS_MUL: begin
        case (step)
          0: m = bit_of(ST_U);
          1: m = bit_of(ST_E) | bit_of(ST_M);
          2, 3, 4: m = bit_of(ST_M);
          5: m = bit_of(ST_N);
          6: m = bit_of(ST_N) | bit_of(ST_A);
          7: m = bit_of(ST_R);
          default: m = '0;
        endcase
      end
      CLS_DIV: begin
        if (step == 0) m = bit_of(ST_U);
        else if (step == 1) m = bit_of(ST_A);
        else if (step == 2) m = bit_of(ST_R);
        else if (step < 3 + div_d) m = bit_of(ST_D);
        else begin
          k = step - 3 - div_d;
          case (k)
            0, 2: m = bit_of(ST_D) | bit_of(ST_A);
            1, 3: m = bit_of(ST_D) | bit_of(ST_R);
            4: m = bit_of(ST_A);
            5: m = bit_of(ST_R);
            default: m = '0;
          endcase
        end
      end
      CLS_CMP: begin
        case (step)
          0: m = bit_of(ST_U);
          1: m = bit_of(ST_A);
          2: m = bit_of(ST_R);
          default: m = '0;
        endcase
      end
      default: begin
        case (step)
          0: m = bit_of(ST_U);
          1: m = bit_of(ST_S);
          default: m = '0;
        endcase
      end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fpsi_pattern_rom.sv
module fpsi_pattern_rom #(
  parameter int unsigned DEPTH = 36,
  parameter int unsigned DIV_D = 27
) (
  input  fpsi_pkg::op_cls_e cls_i,
  output logic [DEPTH-1:0][fpsi_pkg::NUM_STAGES-1:0] pat_o
);
  // one row of stage use per future cycle of the requested class
  for (genvar j = 0; j < DEPTH; j++) begin : g_step
    assign pat_o[j] = fpsi_pkg::stage_use(cls_i, j, DIV_D);
  end
endmodule

// File: rtl/fpsi_resv_table.sv
module fpsi_resv_table #(
  parameter int unsigned DEPTH = 36
) (
  input  logic clk,
  input  logic rst,
  input  logic [DEPTH-1:0][fpsi_pkg::NUM_STAGES-1:0] pat_i,
  input  logic commit_i,
  output logic conflict_o
);
  localparam int unsigned W = fpsi_pkg::NUM_STAGES;

  // occ_q[j]: stages promised for the cycle j steps from now
  logic [DEPTH-1:0][W-1:0] occ_q;
  logic [DEPTH-1:0][W-1:0] occ_d;
  logic [DEPTH-1:0]        hit;

  for (genvar j = 0; j < DEPTH; j++) begin : g_row
    assign hit[j] = |(pat_i[j] & occ_q[j]);
    if (j < DEPTH - 1) begin : g_mid
      assign occ_d[j] = occ_q[j+1] | (commit_i ? pat_i[j+1] : '0);
    end else begin : g_last
      assign occ_d[j] = '0;
    end
  end

  assign conflict_o = |hit;

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_d;
  end
endmodule

// File: rtl/fpsi_cpl_track.sv
module fpsi_cpl_track #(
  parameter int unsigned DIV_D = 27
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  fpsi_pkg::op_cls_e cls_i,
  output logic [fpsi_pkg::NUM_CLS-1:0] done_o
);
  for (genvar c = 0; c < fpsi_pkg::NUM_CLS; c++) begin : g_cls
    localparam fpsi_pkg::op_cls_e CLS = fpsi_pkg::op_cls_e'(3'(c));
    localparam int unsigned LAT = fpsi_pkg::cls_latency(CLS, DIV_D);
    logic [LAT-1:0] sr_q;
    logic           start;

    assign start = fire_i && (cls_i == CLS);

    always_ff @(posedge clk) begin
      if (rst) sr_q <= '0;
      else     sr_q <= {start, sr_q[LAT-1:1]};
    end

    assign done_o[c] = sr_q[0];
  end
endmodule

// File: rtl/fp_stage_issue.sv
module fp_stage_issue #(
  parameter int unsigned DIV_D_CYCLES = 27
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid_i,
  input  logic [2:0] req_op_i,
  output logic       grant_o,
  output logic       stall_o,
  output logic [4:0] done_o
);
  // longest pattern is the divide; it also covers the 8-step multiply
  localparam int unsigned DEPTH = 9 + DIV_D_CYCLES;
  localparam int unsigned W     = fpsi_pkg::NUM_STAGES;

  fpsi_pkg::op_cls_e       cls;
  logic [DEPTH-1:0][W-1:0] pat;
  logic                    conflict;
  logic                    issue;
  logic                    grant_q;
  logic                    stall_q;

  assign cls   = fpsi_pkg::decode_op(req_op_i);
  assign issue = req_valid_i && !conflict;

  fpsi_pattern_rom #(.DEPTH(DEPTH), .DIV_D(DIV_D_CYCLES)) u_rom (
    .cls_i (cls),
    .pat_o (pat)
  );

  fpsi_resv_table #(.DEPTH(DEPTH)) u_table (
    .clk        (clk),
    .rst        (rst),
    .pat_i      (pat),
    .commit_i   (issue),
    .conflict_o (conflict)
  );

  fpsi_cpl_track #(.DIV_D(DIV_D_CYCLES)) u_cpl (
    .clk    (clk),
    .rst    (rst),
    .fire_i (issue),
    .cls_i  (cls),
    .done_o (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      grant_q <= issue;
      stall_q <= req_valid_i && conflict;
    end
  end

  assign grant_o = grant_q;
  assign stall_o = stall_q;
endmodule

// File: rtl/fp_stage_issue_chk.sv
module fp_stage_issue_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       grant_o,
  input logic       stall_o,
  input logic [4:0] done_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!grant_o && !stall_o && done_o == 5'd0));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_o && stall_o));

  // R2
  answered_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> (grant_o || stall_o));

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> (!grant_o && !stall_o));

  // R8
  add_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && $past(req_op_i) == 3'd0 && req_valid_i && req_op_i == 3'd0) |=> stall_o);

  // R10
  add_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o[0] |-> ($past(grant_o, 3) && $past(req_op_i, 4) == 3'd0));

  // R10, R11
  neg_done_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_o && ($past(req_op_i) == 3'd3 || $past(req_op_i) > 3'd4)) |=> done_o[3]);
endmodule

bind fp_stage_issue fp_stage_issue_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .grant_o     (grant_o),
  .stall_o     (stall_o),
  .done_o      (done_o)
);

// File: tb/test_fp_stage_issue.sv
module test_fp_stage_issue;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [2:0] op  = 3'd0;
  logic       grant_o;
  logic       stall_o;
  logic [4:0] done_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  fp_stage_issue i_fp_stage_issue (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req),
    .req_op_i    (op),
    .grant_o     (grant_o),
    .stall_o     (stall_o),
    .done_o      (done_o)
  );

  // fields: first op, second op, offset of second request, expected stall cycles
  // codes (R3): 0 add, 1 mul, 2 div, 3 neg, 4 cmp
  localparam int NV = 29;
  localparam logic [21:0] VEC [NV] = '{
    {3'd1, 3'd0, 8'd1,  8'd0},  // R5
    {3'd1, 3'd0, 8'd3,  8'd0},  // R5
    {3'd1, 3'd0, 8'd4,  8'd2},  // R5
    {3'd1, 3'd0, 8'd5,  8'd1},  // R5
    {3'd1, 3'd0, 8'd6,  8'd0},  // R5
    {3'd1, 3'd0, 8'd7,  8'd0},  // R5
    {3'd0, 3'd1, 8'd1,  8'd0},  // R6
    {3'd0, 3'd1, 8'd2,  8'd0},  // R6
    {3'd0, 3'd2, 8'd1,  8'd1},  // R6
    {3'd0, 3'd2, 8'd2,  8'd0},  // R6
    {3'd2, 3'd0, 8'd27, 8'd0},  // R7
    {3'd2, 3'd0, 8'd28, 8'd6},  // R7
    {3'd2, 3'd0, 8'd31, 8'd3},  // R7
    {3'd2, 3'd0, 8'd33, 8'd1},  // R7
    {3'd2, 3'd0, 8'd34, 8'd0},  // R7
    {3'd0, 3'd0, 8'd1,  8'd2},  // R8
    {3'd0, 3'd0, 8'd2,  8'd1},  // R8
    {3'd0, 3'd0, 8'd3,  8'd0},  // R8
    {3'd1, 3'd1, 8'd1,  8'd3},  // R8
    {3'd1, 3'd1, 8'd3,  8'd1},  // R8
    {3'd1, 3'd1, 8'd4,  8'd0},  // R8
    {3'd3, 3'd3, 8'd1,  8'd0},  // R8
    {3'd4, 3'd4, 8'd1,  8'd0},  // R8
    {3'd1, 3'd4, 8'd5,  8'd1},  // R4
    {3'd1, 3'd4, 8'd4,  8'd0},  // R4
    {3'd0, 3'd3, 8'd2,  8'd1},  // R4
    {3'd3, 3'd0, 8'd1,  8'd0},  // R4
    {3'd0, 3'd7, 8'd2,  8'd1},  // R11
    {3'd2, 3'd2, 8'd31, 8'd1}   // R8
  };

  task automatic check(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int cls_of(input logic [2:0] c);
    return (c > 3'd4) ? 3 : int'(c);
  endfunction

  function automatic int lat_of(input int c);
    case (c)
      0: return 4;
      1: return 8;
      2: return 36;
      4: return 3;
      default: return 2;
    endcase
  endfunction

  task automatic idle(input int n);
    req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input logic [2:0] oa, input logic [2:0] ob,
                         input int gap, input int exp_st, input string rq);
    int n;
    int c;
    idle(40);
    req = 1'b1;
    op  = oa;
    @(negedge clk);
    check({rq, " first op granted on empty table (R4)"}, int'(grant_o), 1);
    if (gap > 1) begin
      req = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
    req = 1'b1;
    op  = ob;
    n   = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (grant_o) break;
      if (!stall_o) begin
        check("R2 request answered", 0, 1);
        break;
      end
      n++;  // R9: held request is retried
    end
    req = 1'b0;
    check({rq, " stall cycles"}, n, exp_st);
    c = cls_of(ob);
    repeat (lat_of(c) - 1) @(negedge clk);
    check("R10 completion pulse high", int'(done_o[c]), 1);
    @(negedge clk);
    check("R10 completion pulse width", int'(done_o[c]), 0);
  endtask

  initial begin
    int seen;
    // R1: quiet during reset
    repeat (3) @(negedge clk);
    check("R1 grant in reset", int'(grant_o), 0);
    check("R1 stall in reset", int'(stall_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);

    // R2: no request, no verdict
    idle(3);
    check("R2 idle grant", int'(grant_o), 0);
    check("R2 idle stall", int'(stall_o), 0);

    // R3 R4 R5 R6 R7 R8 R9 R11: offset table
    for (int v = 0; v < NV; v++) begin
      run_vec(VEC[v][21:19], VEC[v][18:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]),
              $sformatf("vec%0d", v));
    end

    // R10: compare then negate one cycle later finish together
    idle(40);
    req = 1'b1;
    op  = 3'd4;
    @(negedge clk);
    check("R10 compare granted", int'(grant_o), 1);
    op = 3'd3;
    @(negedge clk);
    check("R10 negate granted", int'(grant_o), 1);
    req = 1'b0;
    @(negedge clk);
    check("R10 simultaneous completions", int'(done_o), 5'b11000);

    // R1: reset drops reservations and pending completions
    idle(40);
    req = 1'b1;
    op  = 3'd2;
    @(negedge clk);
    check("R1 divide granted", int'(grant_o), 1);
    req = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    req = 1'b1;
    op  = 3'd0;
    @(negedge clk);
    check("R1 add after reset granted", int'(grant_o), 1);
    req = 1'b0;
    seen = 0;
    repeat (45) begin
      @(negedge clk);
      if (done_o[2]) seen++;
    end
    check("R1 cancelled divide never completes", seen, 0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule